// File: doc/BRIEF.md
# Indexed CRT Controller Register Bank with Write Protection

This block gives a host access to the programming registers of a CRT timing core. Access goes through two ports. An index strobe loads a pointer. A data strobe then reads or writes the byte that the pointer selects. The pointer keeps only its five low bits, so any 8-bit index value reaches one of 32 byte-wide registers.

Two write-protect inputs guard the horizontal and vertical timing registers. Register 07 packs bit 8 of five vertical values. Each of its bits is guarded by the protect input that covers the value it extends, so a single overflow byte can be partly writable. A blocked write leaves the stored bits unchanged and raises no error.

The block joins each vertical value from its low byte and its overflow bit, giving 9-bit values for the timing core. These outputs are driven only while the adapter-mode input selects the graphics-adapter timing mode.

Top module: `crtc_regfile`

## Requirements
- R1: After reset the index is 0, all 32 registers are 0, the read data is 0 and every vertical output is 0.
- R2: An index write stores `wdata_i[4:0]`. `idx_o` returns the stored value with bits 7:5 reading as 0.
- R3: Index values 20h–FFh alias onto registers 00h–1Fh through their low five bits, for both reads and writes.
- R4: A data read strobe loads `rdata_o` at the next rising clock edge with the register the index selects. `rdata_o` then holds that value until the next read strobe.
- R5: While `wp_i[0]` is 1, data writes to registers 00h, 02h, 03h, 04h, 05h and 06h leave them unchanged.
- R6: While `wp_i[1]` is 1, data writes to register 01h leave it unchanged. `wp_i[0]` has no effect on register 01h.
- R7: In register 07h, bits 0, 2 and 3 are guarded by `wp_i[0]`, and bits 1 and 4 are guarded by `wp_i[1]`. The writable bits of a partly guarded write still update.
- R8: Bits 7:5 of register 07h always read as 0.
- R9: While `vga_mode_i` is 1, the outputs are assembled as follows:
  - `vtotal_o` = {07h[0], 06h}
  - `vdisp_end_o` = {07h[1], 12h}
  - `vretrace_o` = {07h[2], 10h}
  - `vblank_o` = {07h[3], 15h}
  - `line_cmp_o` = {07h[4], 18h}
- R10: While `vga_mode_i` is 0, all five vertical outputs are 0, and the stored registers keep their values.
- R11: When an index write and a data write arrive in the same cycle, the data goes to the register selected by the index held before that cycle.
- R12: Registers outside the guarded set (for example 08h and 1Fh) accept writes whatever the value of `wp_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| idx_wr_i | input | 1 | Index write strobe |
| data_wr_i | input | 1 | Data write strobe to the selected register |
| data_rd_i | input | 1 | Data read strobe |
| wdata_i | input | 8 | Write data for the index and data ports |
| wp_i | input | 2 | Write-protect controls: bit 0 guards timing registers, bit 1 guards display end and line compare |
| vga_mode_i | input | 1 | 1 enables the vertical timing outputs |
| idx_o | output | 8 | Index readback |
| rdata_o | output | 8 | Registered read data |
| vtotal_o | output | 9 | Vertical total |
| vdisp_end_o | output | 9 | Vertical display end |
| vretrace_o | output | 9 | Vertical retrace start |
| vblank_o | output | 9 | Vertical blank start |
| line_cmp_o | output | 9 | Line compare |

## Verification
Writes are tried with both protect bits clear, with each bit set alone, and with both set. This separates the register group that each control guards, and it exposes any swap of the two controls at the overflow byte. The overflow byte is written with all ones under each protect setting. The bits that survive show the per-bit split, and show that the unused top bits never store. Indices above 1Fh and an index update in the same cycle as a data write separate address truncation from an off-by-one in pointer timing.

// File: rtl/crtc_pkg.sv
package crtc_pkg;
  localparam int unsigned IDX_W  = 5;
  localparam int unsigned DW     = 8;
  localparam int unsigned NREG   = 1 << IDX_W;
  localparam int unsigned VW     = DW + 1;

  localparam logic [IDX_W-1:0] A_DEND = 5'h01;
  localparam logic [IDX_W-1:0] A_VTOT = 5'h06;
  localparam logic [IDX_W-1:0] A_OVF  = 5'h07;
  localparam logic [IDX_W-1:0] A_VRS  = 5'h10;
  localparam logic [IDX_W-1:0] A_VDE  = 5'h12;
  localparam logic [IDX_W-1:0] A_VBS  = 5'h15;
  localparam logic [IDX_W-1:0] A_LC   = 5'h18;

  // overflow bit positions (decoded by the timing core)
  localparam int unsigned OB_VT  = 0;
  localparam int unsigned OB_VDE = 1;
  localparam int unsigned OB_VRS = 2;
  localparam int unsigned OB_VBS = 3;
  localparam int unsigned OB_LC  = 4;

  localparam logic [DW-1:0] OVF_USED = 8'h1F;
  localparam logic [DW-1:0] OVF_WP0  = 8'h0D;
  localparam logic [DW-1:0] OVF_WP1  = 8'h12;

  function automatic logic [DW-1:0] wr_mask(input logic [IDX_W-1:0] sel,
                                            input logic [1:0] wp);
    logic [DW-1:0] m;
    m = '1;
    unique case (sel)
      5'h00, 5'h02, 5'h03, 5'h04, 5'h05, 5'h06: if (wp[0]) m = '0;
      A_DEND: if (wp[1]) m = '0;
      A_OVF: begin
        m = OVF_USED;
        if (wp[0]) m = m & ~OVF_WP0;
        if (wp[1]) m = m & ~OVF_WP1;
      end
      default: m = '1;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/crtc_index_reg.sv
module crtc_index_reg
  import crtc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [IDX_W-1:0] sel_o,
  output logic [DW-1:0]    idx_o
);
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   idx_q <= '0;
    else if (wr_i) idx_q <= wdata_i[IDX_W-1:0];
  end

  assign sel_o = idx_q;
  assign idx_o = {{(DW-IDX_W){1'b0}}, idx_q};

  // R2
  idx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(sel_o));

  // R3
  idx_trunc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> sel_o == $past(wdata_i[IDX_W-1:0]));
endmodule

// File: rtl/crtc_reg_bank.sv
module crtc_reg_bank
  import crtc_pkg::*;
(
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_i,
  input  logic                      rd_i,
  input  logic [IDX_W-1:0]          sel_i,
  input  logic [DW-1:0]             wdata_i,
  input  logic [1:0]                wp_i,
  output logic [DW-1:0]             rdata_o,
  output logic [NREG-1:0][DW-1:0]   regs_o
);
  logic [NREG-1:0][DW-1:0] regs_q;
  logic [DW-1:0]           mask;
  logic [DW-1:0]           rdata_q;

  assign mask = wr_mask(sel_i, wp_i);

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) regs_q[i] <= '0;
      else if (wr_i && sel_i == IDX_W'(i))
        regs_q[i] <= (regs_q[i] & ~mask) | (wdata_i & mask);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= regs_q[sel_i];
  end

  assign rdata_o = rdata_q;
  assign regs_o  = regs_q;

  // R5
  wp0_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wp_i[0] && sel_i == 5'h00) |=> $stable(regs_q[0]));

  // R6
  wp1_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wp_i[1] && sel_i == A_DEND) |=> $stable(regs_q[A_DEND]));

  // R7
  ovf_split_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wp_i == 2'b01 && sel_i == A_OVF) |=>
      ($stable(regs_q[A_OVF][OB_VT]) &&
       regs_q[A_OVF][OB_LC] == $past(wdata_i[OB_LC])));

  // R8
  ovf_unused_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    regs_q[A_OVF][DW-1:5] == '0);

  // R12
  free_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i == 5'h08) |=> regs_q[8] == $past(wdata_i));

  // R4
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));
endmodule

// File: rtl/crtc_vtiming_pack.sv
module crtc_vtiming_pack
  import crtc_pkg::*;
(
  input  logic                    en_i,
  input  logic [NREG-1:0][DW-1:0] regs_i,
  output logic [VW-1:0]           vtotal_o,
  output logic [VW-1:0]           vdisp_end_o,
  output logic [VW-1:0]           vretrace_o,
  output logic [VW-1:0]           vblank_o,
  output logic [VW-1:0]           line_cmp_o
);
  logic [DW-1:0] ovf;
  assign ovf = regs_i[A_OVF];

  always_comb begin
    vtotal_o    = '0;
    vdisp_end_o = '0;
    vretrace_o  = '0;
    vblank_o    = '0;
    line_cmp_o  = '0;
    if (en_i) begin
      vtotal_o    = {ovf[OB_VT],  regs_i[A_VTOT]};
      vdisp_end_o = {ovf[OB_VDE], regs_i[A_VDE]};
      vretrace_o  = {ovf[OB_VRS], regs_i[A_VRS]};
      vblank_o    = {ovf[OB_VBS], regs_i[A_VBS]};
      line_cmp_o  = {ovf[OB_LC],  regs_i[A_LC]};
    end
  end
endmodule

// File: rtl/crtc_regfile.sv
module crtc_regfile
  import crtc_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          idx_wr_i,
  input  logic          data_wr_i,
  input  logic          data_rd_i,
  input  logic [7:0]    wdata_i,
  input  logic [1:0]    wp_i,
  input  logic          vga_mode_i,
  output logic [7:0]    idx_o,
  output logic [7:0]    rdata_o,
  output logic [8:0]    vtotal_o,
  output logic [8:0]    vdisp_end_o,
  output logic [8:0]    vretrace_o,
  output logic [8:0]    vblank_o,
  output logic [8:0]    line_cmp_o
);
  logic [IDX_W-1:0]        sel;
  logic [NREG-1:0][DW-1:0] regs;

  crtc_index_reg u_idx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (idx_wr_i),
    .wdata_i (wdata_i),
    .sel_o   (sel),
    .idx_o   (idx_o)
  );

  crtc_reg_bank u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (data_wr_i),
    .rd_i    (data_rd_i),
    .sel_i   (sel),
    .wdata_i (wdata_i),
    .wp_i    (wp_i),
    .rdata_o (rdata_o),
    .regs_o  (regs)
  );

  crtc_vtiming_pack u_vt (
    .en_i        (vga_mode_i),
    .regs_i      (regs),
    .vtotal_o    (vtotal_o),
    .vdisp_end_o (vdisp_end_o),
    .vretrace_o  (vretrace_o),
    .vblank_o    (vblank_o),
    .line_cmp_o  (line_cmp_o)
  );

  // R11
  same_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_wr_i && data_wr_i && sel == A_LC && vga_mode_i) |=>
      (!vga_mode_i || line_cmp_o[DW-1:0] == $past(wdata_i)));

  // R10
  mode_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vga_mode_i |-> (vtotal_o | vdisp_end_o | vretrace_o | vblank_o | line_cmp_o) == '0);
endmodule

// File: tb/tb_crtc_regfile.sv
`timescale 1ns/1ps
module tb_crtc_regfile;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       idx_wr = 1'b0, data_wr = 1'b0, data_rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [1:0] wp = '0;
  logic       mode = 1'b1;
  logic [7:0] idx_o, rdata;
  logic [8:0] vt, vde, vrs, vbs, lc;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  crtc_regfile dut (
    .clk_i(clk), .rst_ni(rst_n), .idx_wr_i(idx_wr), .data_wr_i(data_wr),
    .data_rd_i(data_rd), .wdata_i(wdata), .wp_i(wp), .vga_mode_i(mode),
    .idx_o(idx_o), .rdata_o(rdata), .vtotal_o(vt), .vdisp_end_o(vde),
    .vretrace_o(vrs), .vblank_o(vbs), .line_cmp_o(lc)
  );

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_idx(input logic [7:0] v);
    @(negedge clk); idx_wr = 1'b1; wdata = v;
    @(negedge clk); idx_wr = 1'b0;
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk); data_wr = 1'b1; wdata = v;
    @(negedge clk); data_wr = 1'b0;
  endtask

  task automatic wr_at(input logic [7:0] a, input logic [7:0] v);
    set_idx(a); wr(v);
  endtask

  task automatic rd_at(input logic [7:0] a, input string req, input logic [7:0] exp);
    set_idx(a);
    @(negedge clk); data_rd = 1'b1;
    @(negedge clk); data_rd = 1'b0;
    chk(req, {1'b0, rdata}, {1'b0, exp});
  endtask

  task automatic t_reset();
    chk("R1 idx", {1'b0, idx_o}, 9'h0);
    chk("R1 rdata", {1'b0, rdata}, 9'h0);
    chk("R1 vtotal", vt, 9'h0);
    chk("R1 linecmp", lc, 9'h0);
    rd_at(8'h06, "R1 reg06", 8'h00);
  endtask

  task automatic t_index();
    set_idx(8'hEB);
    chk("R2 idx readback", {1'b0, idx_o}, 9'h00B);
    wr_at(8'h2A, 8'h5C);
    rd_at(8'h0A, "R3 alias write", 8'h5C);
    rd_at(8'hCA, "R3 alias read", 8'h5C);
  endtask

  task automatic t_read_hold();
    wr_at(8'h09, 8'h3E);
    rd_at(8'h09, "R4 read", 8'h3E);
    wr(8'h77);
    @(negedge clk);
    chk("R4 hold without strobe", {1'b0, rdata}, 9'h03E);
  endtask

  task automatic t_protect();
    wp = 2'b00;
    wr_at(8'h00, 8'h11); wr_at(8'h01, 8'h22); wr_at(8'h05, 8'h33);
    wp = 2'b01;
    wr_at(8'h00, 8'hAA); wr_at(8'h05, 8'hAA); wr_at(8'h01, 8'h44);
    rd_at(8'h00, "R5 reg00 blocked", 8'h11);
    rd_at(8'h05, "R5 reg05 blocked", 8'h33);
    rd_at(8'h01, "R6 wp0 no effect on 01", 8'h44);
    wp = 2'b10;
    wr_at(8'h01, 8'hBB); wr_at(8'h02, 8'h66);
    rd_at(8'h01, "R6 reg01 blocked", 8'h44);
    rd_at(8'h02, "R5 reg02 open under wp1", 8'h66);
    wp = 2'b11;
    wr_at(8'h08, 8'h9D); wr_at(8'h1F, 8'hE4);
    rd_at(8'h08, "R12 reg08 free", 8'h9D);
    rd_at(8'h1F, "R12 reg1F free", 8'hE4);
    wp = 2'b00;
  endtask

  task automatic t_overflow();
    wp = 2'b00; wr_at(8'h07, 8'h00);
    wp = 2'b01; wr_at(8'h07, 8'hFF);
    rd_at(8'h07, "R7 wp0 keeps 0,2,3", 8'h12);
    wp = 2'b10; wr_at(8'h07, 8'hFF);
    rd_at(8'h07, "R7 wp1 keeps 1,4", 8'h1F);
    wp = 2'b10; wr_at(8'h07, 8'h00);
    rd_at(8'h07, "R7 wp1 clears 0,2,3", 8'h12);
    wp = 2'b00; wr_at(8'h07, 8'hE0);
    rd_at(8'h07, "R8 unused bits zero", 8'h00);
  endtask

  task automatic t_assemble();
    wp = 2'b00;
    wr_at(8'h06, 8'h0D); wr_at(8'h12, 8'h8F); wr_at(8'h10, 8'h9C);
    wr_at(8'h15, 8'h96); wr_at(8'h18, 8'hFF);
    wr_at(8'h07, 8'h15);
    chk("R9 vtotal", vt, 9'h10D);
    chk("R9 vdisp_end", vde, 9'h08F);
    chk("R9 vretrace", vrs, 9'h19C);
    chk("R9 vblank", vbs, 9'h096);
    chk("R9 line_cmp", lc, 9'h1FF);
    mode = 1'b0;
    @(negedge clk);
    chk("R10 vtotal off", vt, 9'h0);
    chk("R10 line_cmp off", lc, 9'h0);
    rd_at(8'h06, "R10 stored kept", 8'h0D);
    mode = 1'b1;
    @(negedge clk);
    chk("R10 vtotal back", vt, 9'h10D);
  endtask

  task automatic t_same_cycle();
    set_idx(8'h18);
    @(negedge clk); idx_wr = 1'b1; data_wr = 1'b1; wdata = 8'h03;
    @(negedge clk); idx_wr = 1'b0; data_wr = 1'b0;
    rd_at(8'h18, "R11 old index used", 8'h03);
    rd_at(8'h03, "R11 new index untouched", 8'h00);
  endtask

  initial begin
    #(200000 * 10);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_index();
    t_read_hold();
    t_protect();
    t_overflow();
    t_assemble();
    t_same_cycle();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule